// File: doc/BRIEF.md
# DMA Write-Command Segmenter

This block takes one programmed memory-to-bus DMA write (start address and byte count) and splits it into a series of bus write segments. Each segment carries an address, a length and a command flag that selects either a plain Memory Write or a Memory Write and Invalidate (MWI). The block decides once, at the start of the transfer, whether MWI may be used. That decision depends on the cache line size register value, the MWI enable bit of the bus side that serves the channel, and the channel's data queue capacity.

When MWI is allowed, the block cuts the transfer at cache-line boundaries. Any stretch before the first boundary goes out as a plain write. Each complete aligned line after that goes out as its own MWI segment, and a partial line at the end goes out as a plain write. When MWI is not allowed, the whole transfer goes out as a single plain write.

Segments leave over a valid/ready handshake, at most one per cycle. A bus-request qualifier holds back an MWI segment until the queue holds a full line of data. A one-cycle done pulse follows the last segment. Bus protocol signalling, data movement, the queue itself and locked bus access all lie outside this block.

Top module: `dma_wr_segmenter`

## Requirements
- R1: MWI is used only when `cls_dw_i` (line size in DWORDs) is a power of two from 1 to 32. Zero or any other value makes every segment plain (`seg_mwi_o`=0).
- R2: MWI is used only when the line size in bytes (`cls_dw_i`×4) does not exceed the parameter `QUEUE_BYTES` (64 by default; 256 for a primary-side channel).
- R3: MWI is used only when `mwi_en_i` is 1 at the start of the transfer.
- R4: When MWI is not allowed, a nonzero transfer yields exactly one plain segment, with address equal to the start address and length equal to the byte count.
- R5: When MWI is allowed and the start address is not line-aligned, the first segment is plain. It starts at the start address, and its length is the distance to the next line boundary or the byte count, whichever is smaller.
- R6: When MWI is allowed, each complete line-aligned line that remains is sent as one segment with `seg_mwi_o`=1, a line-aligned address and a length of one line.
- R7: When MWI is allowed, a final remainder shorter than one line is sent as one plain segment.
- R8: Segments are contiguous and in ascending address order. Their lengths add up to the byte count, and no segment has length zero.
- R9: While `seg_valid_o`=1 and `seg_ready_i`=0, the descriptor (address, length, command) does not change. With ready held high, one segment is accepted per cycle.
- R10: `bus_req_o` is `seg_valid_o` for a plain segment. For an MWI segment it is `seg_valid_o` and (`fill_bytes_i` ≥ segment length).
- R11: `done_o` is high for exactly one cycle, the cycle after the last segment is accepted. A transfer with a byte count of 0 produces no segment, and `done_o` follows in the cycle after the start.
- R12: A `start_i` pulse while `busy_o`=1 is ignored; the segments of the running transfer do not change.
- R13: After reset, `seg_valid_o`, `done_o`, `busy_o` and `bus_req_o` are 0.
- R14: The MWI decision and the line size are captured at the start. Changes to `cls_dw_i` or `mwi_en_i` during a transfer do not affect its segments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| start_addr_i | input | ADDR_W | Transfer start address (DWORD multiple) |
| byte_count_i | input | LEN_W | Transfer length in bytes (DWORD multiple) |
| cls_dw_i | input | 8 | Cache line size in DWORDs |
| mwi_en_i | input | 1 | MWI enable of the serving bus side |
| fill_bytes_i | input | FILL_W | Current queue fill level in bytes |
| seg_valid_o | output | 1 | Segment descriptor valid |
| seg_ready_i | input | 1 | Segment descriptor accepted |
| seg_addr_o | output | ADDR_W | Segment start address |
| seg_len_o | output | LEN_W | Segment length in bytes |
| seg_mwi_o | output | 1 | 1 = MWI command, 0 = plain Memory Write |
| bus_req_o | output | 1 | Bus-request qualifier for the current segment |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse after the last segment |

## Verification
The bench targets the MWI gate at its edges:
- a line size of 0, a non-power-of-two size and a 32-DWORD size that exceeds the 64-byte queue; a faulty gate would let MWI through on any of these.
- unaligned starts whose head covers the whole transfer, and transfers that end exactly on a boundary; a cutter that is off by one here would emit a zero-length tail or a misaligned MWI segment.
- back-pressure, start pulses and changes to the line size or enable bit while a transfer runs; a design that reloads or re-decides mid-transfer would produce segments that stop matching the reference list.
- random queue fill levels; a premature `bus_req_o` on an MWI segment shows that the full-line guard is missing.

// File: rtl/seg_pkg.sv
package seg_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_FIN  = 2'd2
  } seg_state_e;

  // Line size in DWORDs is legal only as a power of two in 1..32.
  function automatic logic cls_legal(input logic [7:0] cls_dw);
    return (cls_dw != 8'd0) && ((cls_dw & (cls_dw - 8'd1)) == 8'd0) &&
           (cls_dw <= 8'd32);
  endfunction

  // Bytes per line for a DWORD count.
  function automatic logic [15:0] line_bytes_of(input logic [7:0] cls_dw);
    return {6'd0, cls_dw, 2'b00};
  endfunction

  // Smaller of two lengths.
  function automatic logic [15:0] min_len(input logic [15:0] a,
                                          input logic [15:0] b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/mwi_gate.sv
module mwi_gate #(
  parameter int LEN_W       = 16,
  parameter int QUEUE_BYTES = 64
) (
  input  logic [7:0]       cls_dw_i,
  input  logic             mwi_en_i,
  output logic             elig_o,
  output logic [LEN_W-1:0] line_o
);
  import seg_pkg::*;

  localparam logic [15:0] QB = 16'(QUEUE_BYTES);

  logic        size_ok;
  logic        fits_ok;
  logic [15:0] line_full;

  always_comb begin
    line_full = line_bytes_of(cls_dw_i);
    size_ok   = cls_legal(cls_dw_i);
    fits_ok   = (line_full <= QB);
    elig_o    = size_ok && fits_ok && mwi_en_i;
    line_o    = LEN_W'(line_full);
  end

endmodule

// File: rtl/seg_cutter.sv
module seg_cutter #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic [ADDR_W-1:0] cur_addr_i,
  input  logic [LEN_W-1:0]  remaining_i,
  input  logic              elig_i,
  input  logic [LEN_W-1:0]  line_i,
  output logic [LEN_W-1:0]  seg_len_o,
  output logic              seg_mwi_o,
  output logic              head_cut_o
);
  logic [LEN_W-1:0] offset;
  logic [LEN_W-1:0] to_bound;

  always_comb begin
    offset     = cur_addr_i[LEN_W-1:0] & (line_i - LEN_W'(1));
    to_bound   = line_i - offset;
    head_cut_o = 1'b0;
    seg_mwi_o  = 1'b0;
    if (!elig_i) begin
      seg_len_o = remaining_i;
    end else if (offset != '0) begin
      head_cut_o = 1'b1;
      seg_len_o  = (to_bound < remaining_i) ? to_bound : remaining_i;
    end else if (remaining_i >= line_i) begin
      seg_len_o = line_i;
      seg_mwi_o = 1'b1;
    end else begin
      seg_len_o = remaining_i;
    end
  end

endmodule

// File: rtl/seg_ctrl.sv
module seg_ctrl #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [LEN_W-1:0]  byte_count_i,
  input  logic              elig_i,
  input  logic [LEN_W-1:0]  line_i,
  input  logic [LEN_W-1:0]  seg_len_i,
  input  logic              seg_ready_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [LEN_W-1:0]  remaining_o,
  output logic              elig_o,
  output logic [LEN_W-1:0]  line_o,
  output logic              seg_valid_o,
  output logic              done_o,
  output logic              busy_o
);
  import seg_pkg::*;

  seg_state_e state_q;
  logic       take_start;
  logic       seg_accept;
  logic       last_seg;

  assign take_start  = start_i && (state_q == S_IDLE);
  assign seg_valid_o = (state_q == S_RUN);
  assign seg_accept  = seg_valid_o && seg_ready_i;
  assign last_seg    = (seg_len_i == remaining_o);
  assign done_o      = (state_q == S_FIN);
  assign busy_o      = (state_q != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      cur_addr_o  <= '0;
      remaining_o <= '0;
      elig_o      <= 1'b0;
      line_o      <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (take_start) begin
          cur_addr_o  <= start_addr_i;
          remaining_o <= byte_count_i;
          elig_o      <= elig_i;
          line_o      <= line_i;
          state_q     <= (byte_count_i == '0) ? S_FIN : S_RUN;
        end
        S_RUN: if (seg_accept) begin
          cur_addr_o  <= cur_addr_o + ADDR_W'(seg_len_i);
          remaining_o <= remaining_o - seg_len_i;
          if (last_seg) state_q <= S_FIN;
        end
        S_FIN:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R11: done lasts one cycle
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R12: no reload of the remaining count while busy
  p_no_reload_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> (remaining_o <= $past(remaining_o)));

  // R14: captured decision frozen for the whole transfer
  p_elig_frozen_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> ($stable(elig_o) && $stable(line_o)));

  // R9: stalled descriptor state does not move
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid_o && !seg_ready_i) |=>
      (seg_valid_o && $stable(cur_addr_o) && $stable(remaining_o)));

endmodule

// File: rtl/dma_wr_segmenter.sv
module dma_wr_segmenter #(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int QUEUE_BYTES = 64,
  localparam int FILL_W     = $clog2(QUEUE_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [LEN_W-1:0]  byte_count_i,
  input  logic [7:0]        cls_dw_i,
  input  logic              mwi_en_i,
  input  logic [FILL_W-1:0] fill_bytes_i,
  output logic              seg_valid_o,
  input  logic              seg_ready_i,
  output logic [ADDR_W-1:0] seg_addr_o,
  output logic [LEN_W-1:0]  seg_len_o,
  output logic              seg_mwi_o,
  output logic              bus_req_o,
  output logic              busy_o,
  output logic              done_o
);

  logic              elig_now;
  logic [LEN_W-1:0]  line_now;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  remaining;
  logic              elig_q;
  logic [LEN_W-1:0]  line_q;
  logic [LEN_W-1:0]  cut_len;
  logic              cut_mwi;
  logic              head_cut;
  logic              line_present;

  mwi_gate #(.LEN_W(LEN_W), .QUEUE_BYTES(QUEUE_BYTES)) u_gate (
    .cls_dw_i (cls_dw_i),
    .mwi_en_i (mwi_en_i),
    .elig_o   (elig_now),
    .line_o   (line_now)
  );

  seg_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .start_addr_i (start_addr_i),
    .byte_count_i (byte_count_i),
    .elig_i       (elig_now),
    .line_i       (line_now),
    .seg_len_i    (cut_len),
    .seg_ready_i  (seg_ready_i),
    .cur_addr_o   (cur_addr),
    .remaining_o  (remaining),
    .elig_o       (elig_q),
    .line_o       (line_q),
    .seg_valid_o  (seg_valid_o),
    .done_o       (done_o),
    .busy_o       (busy_o)
  );

  seg_cutter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_cut (
    .cur_addr_i  (cur_addr),
    .remaining_i (remaining),
    .elig_i      (elig_q),
    .line_i      (line_q),
    .seg_len_o   (cut_len),
    .seg_mwi_o   (cut_mwi),
    .head_cut_o  (head_cut)
  );

  assign seg_addr_o   = cur_addr;
  assign seg_len_o    = cut_len;
  assign seg_mwi_o    = cut_mwi;
  assign line_present = (LEN_W'(fill_bytes_i) >= cut_len);
  assign bus_req_o    = seg_valid_o && (!cut_mwi || line_present);

  // R4: ineligible transfer never carries MWI
  p_plain_when_ineligible_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid_o && !elig_q) |-> (!seg_mwi_o && seg_len_o == remaining));

  // R6: MWI segment is one aligned line
  p_mwi_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid_o && seg_mwi_o) |->
      (seg_len_o == line_q &&
       (seg_addr_o[LEN_W-1:0] & (line_q - LEN_W'(1))) == '0));

  // R5: a head segment is plain and stops at or before the boundary
  p_head_plain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid_o && head_cut) |-> (!seg_mwi_o && seg_len_o < line_q));

  // R8: no zero-length segment and no overrun
  p_len_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid_o |-> (seg_len_o != '0 && seg_len_o <= remaining));

  // R10: MWI request needs a full line in the queue
  p_req_needs_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && seg_mwi_o) |-> (LEN_W'(fill_bytes_i) >= seg_len_o));

  // R13: nothing asserted while idle
  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!seg_valid_o && !bus_req_o));

endmodule

// File: tb/dma_wr_segmenter_tb.sv
module dma_wr_segmenter_tb;

  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;
  localparam int QB     = 64;
  localparam int FILL_W = $clog2(QB + 1);
  localparam int MAXSEG = 256;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [ADDR_W-1:0] start_addr_i = '0;
  logic [LEN_W-1:0]  byte_count_i = '0;
  logic [7:0]        cls_dw_i = '0;
  logic              mwi_en_i = 1'b0;
  logic [FILL_W-1:0] fill_bytes_i = '0;
  logic              seg_valid_o;
  logic              seg_ready_i = 1'b0;
  logic [ADDR_W-1:0] seg_addr_o;
  logic [LEN_W-1:0]  seg_len_o;
  logic              seg_mwi_o;
  logic              bus_req_o;
  logic              busy_o;
  logic              done_o;

  dma_wr_segmenter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .QUEUE_BYTES(QB)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .byte_count_i(byte_count_i), .cls_dw_i(cls_dw_i), .mwi_en_i(mwi_en_i),
    .fill_bytes_i(fill_bytes_i), .seg_valid_o(seg_valid_o),
    .seg_ready_i(seg_ready_i), .seg_addr_o(seg_addr_o), .seg_len_o(seg_len_o),
    .seg_mwi_o(seg_mwi_o), .bus_req_o(bus_req_o), .busy_o(busy_o),
    .done_o(done_o)
  );

  always #5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  int unsigned exp_addr [MAXSEG];
  int unsigned exp_len  [MAXSEG];
  bit          exp_mwi  [MAXSEG];
  int          exp_kind [MAXSEG];  // 4 whole, 5 head, 6 line, 7 tail
  int          exp_n;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, expv);
    end
  endtask

  function automatic bit ref_legal(input int cls);
    return (cls == 1 || cls == 2 || cls == 4 || cls == 8 ||
            cls == 16 || cls == 32);
  endfunction

  // Which requirement blocks MWI (0 = none)
  function automatic int block_reason(input int cls, input bit en);
    if (!ref_legal(cls)) return 1;
    if (cls * 4 > QB) return 2;
    if (!en) return 3;
    return 0;
  endfunction

  function automatic void push(input int unsigned a, input int unsigned l,
                               input bit m, input int k);
    exp_addr[exp_n] = a; exp_len[exp_n] = l;
    exp_mwi[exp_n] = m;  exp_kind[exp_n] = k;
    exp_n++;
  endfunction

  function automatic void build_expected(input int unsigned addr,
                                         input int unsigned count,
                                         input int cls, input bit en);
    int unsigned line, bnd, head, a, r;
    exp_n = 0;
    if (count == 0) return;
    if (block_reason(cls, en) != 0) begin
      push(addr, count, 1'b0, 4);
      return;
    end
    line = cls * 4;
    bnd  = ((addr + line - 1) / line) * line;
    head = bnd - addr;
    if (head > count) head = count;
    if (head > 0) push(addr, head, 1'b0, 5);
    a = addr + head;
    r = count - head;
    while (r >= line) begin
      push(a, line, 1'b1, 6);
      a += line;
      r -= line;
    end
    if (r > 0) push(a, r, 1'b0, 7);
  endfunction

  function automatic string kind_tag(input int k);
    case (k)
      4: return "R4";
      5: return "R5";
      6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic run_xfer(input int unsigned addr, input int unsigned count,
                          input int cls, input bit en, input bit stress);
    int idx = 0;
    int cyc = 0;
    int mwi_seen = 0;
    int unsigned sum = 0;
    bit prev_stall = 0;
    bit prev_hs = 0;
    bit saw_done = 0;
    logic [ADDR_W-1:0] h_addr = '0;
    logic [LEN_W-1:0]  h_len = '0;
    logic              h_mwi = 1'b0;
    int reason;
    build_expected(addr, count, cls, en);
    reason = block_reason(cls, en);
    @(negedge clk);
    start_i = 1'b1; start_addr_i = addr; byte_count_i = LEN_W'(count);
    cls_dw_i = 8'(cls); mwi_en_i = en;
    @(negedge clk);
    start_i = 1'b0;
    while (cyc < 2000) begin
      seg_ready_i  = stress ? ($urandom % 3 != 0) : 1'b1;
      fill_bytes_i = FILL_W'($urandom % (QB + 1));
      if (stress) begin
        // R12 and R14: disturbances while busy
        start_i  = ($urandom % 4 == 0);
        start_addr_i = $urandom;
        byte_count_i = LEN_W'(($urandom % 64) * 4);
        cls_dw_i = 8'($urandom % 40);
        mwi_en_i = $urandom % 2;
      end
      #1;
      if (done_o) begin
        saw_done = 1;
        check(prev_hs || (exp_n == 0 && cyc == 0), "R11",
              "done timing", cyc, idx);
        check(!seg_valid_o, "R11", "valid during done", seg_valid_o, 0);
        break;
      end
      prev_hs = 0;
      if (!seg_valid_o) begin
        check(0, "R8", "valid dropped mid-transfer", 0, 1);
        break;
      end
      check(bus_req_o == (seg_mwi_o ? (32'(fill_bytes_i) >= 32'(seg_len_o)) : 1'b1),
            "R10", "bus_req", bus_req_o, seg_mwi_o);
      if (prev_stall)
        check(seg_addr_o == h_addr && seg_len_o == h_len && seg_mwi_o == h_mwi,
              "R9", "descriptor changed while stalled", seg_addr_o, h_addr);
      if (seg_ready_i) begin
        if (idx < exp_n) begin
          check(seg_addr_o == exp_addr[idx], kind_tag(exp_kind[idx]),
                "segment address", seg_addr_o, exp_addr[idx]);
          check(seg_len_o == exp_len[idx] && seg_mwi_o == exp_mwi[idx],
                kind_tag(exp_kind[idx]), "segment len/mwi",
                {seg_len_o, 3'b0, seg_mwi_o},
                {exp_len[idx][15:0], 3'b0, exp_mwi[idx]});
        end else begin
          check(0, "R8", "extra segment", idx, exp_n);
        end
        if (seg_mwi_o) mwi_seen++;
        sum += seg_len_o;
        idx++;
        prev_hs = 1;
      end
      prev_stall = !seg_ready_i;
      h_addr = seg_addr_o; h_len = seg_len_o; h_mwi = seg_mwi_o;
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    seg_ready_i = 1'b0;
    check(saw_done, "R11", "done seen", saw_done, 1);
    check(idx == exp_n && sum == count, "R8", "segment count/bytes", sum, count);
    if (reason == 1)
      check(mwi_seen == 0, "R1", "MWI with illegal line size", mwi_seen, 0);
    else if (reason == 2)
      check(mwi_seen == 0, "R2", "MWI with line over queue", mwi_seen, 0);
    else if (reason == 3)
      check(mwi_seen == 0, "R3", "MWI while disabled", mwi_seen, 0);
    @(negedge clk);
    #1;
    check(!done_o && !busy_o && !seg_valid_o, "R11", "after done",
          {done_o, busy_o, seg_valid_o}, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    check(!seg_valid_o && !done_o && !busy_o && !bus_req_o, "R13",
          "reset outputs", {seg_valid_o, done_o, busy_o, bus_req_o}, 0);
    rst_n = 1'b1;
    // Directed corner cases
    run_xfer(32'h8001C, 80, 8, 1, 0);   // R5 R6 R7 worked example
    run_xfer(32'h8001C, 80, 0, 1, 0);   // R1 zero size
    run_xfer(32'h8001C, 80, 3, 1, 0);   // R1 non power of two
    run_xfer(32'h80000, 256, 32, 1, 0); // R2 line over queue
    run_xfer(32'h80000, 256, 16, 1, 0); // R2 line equal to queue
    run_xfer(32'h80004, 64, 8, 0, 0);   // R3 disabled
    run_xfer(32'h80004, 8, 8, 1, 0);    // R5 head covers all
    run_xfer(32'h80040, 96, 8, 1, 0);   // R6 exact lines, no tail
    run_xfer(32'h80040, 0, 8, 1, 0);    // R11 zero count
    run_xfer(32'h80010, 100, 1, 1, 1);  // R14 R12 under disturbance
    // Random transfers
    for (int i = 0; i < 150; i++) begin
      int cls_pick = (i % 5 == 0) ? int'($urandom % 40) : (1 << ($urandom % 6));
      run_xfer(($urandom % 32'h40000) & ~32'h3, ($urandom % 150) * 4,
               cls_pick, ($urandom % 8) != 0, 1);
    end
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule